// File: doc/BRIEF.md
# Serial Receive Queue with Level and Idle-Timeout Signalling

This block sits behind a bit-level serial receiver. Each deserialized character arrives as a one-cycle strobe with its data byte and three error flags: break, parity and framing. The block stores each character together with its flags. A software-style reader removes the oldest entry with a single pop strobe, and data and flags come out together in that one access.

A mode input selects deep queueing or a single holding slot. In deep mode the block keeps up to 32 entries. In single-slot mode the block keeps one entry, and any further character is lost until the slot is read. Three raw conditions are produced:
- A fill-level condition, with a selectable trigger point.
- An idle timeout, which lets the reader collect a trailing group of characters that stays below the trigger point.
- A sticky overrun.

Each raw condition is gated by its own mask bit onto an interrupt output, and the three gated outputs are also ORed into one line. An empty flag lets the reader drain every stored entry in one service pass. A baud-tick input supplies one pulse per bit period for the idle timer.

Top module: `uart_rx_queue`

## Requirements
- R1: With `fifo_en` = 1 the block stores up to 32 characters and returns them in arrival order. Each pop presents `{rd_brk, rd_par, rd_frm, rd_data}` of the oldest entry, and those four fields belong to the same stored character.
- R2: With `fifo_en` = 0 the block holds at most one character. `rx_full` is 1 while it is held, and a second character does not replace it.
- R3: A character strobed while `rx_full` is 1 is discarded. `raw_ovr` is 1 from the next cycle, and the stored entries, including the head shown on the read outputs, are unchanged.
- R4: `raw_ovr` stays 1 until a cycle with `ovr_clr` = 1 and no new overrun. In a cycle where a discard and a clear coincide, the flag stays set.
- R5: `raw_lvl` is 1 while the stored count is at least the trigger, and 0 otherwise. The trigger in deep mode is set by `trig_sel`: 0 gives 4 entries, 1 gives 8, 2 gives 16, 3 gives 24 and 4 gives 28, and codes 5 to 7 give 16. In single-slot mode the trigger is 1.
- R6: `raw_to` becomes 1 at the clock edge that takes the 32nd `baud_tick` counted while the queue is non-empty, below its trigger, and without a push. After only 31 such ticks it is still 0. It never rises in single-slot mode.
- R7: The idle count restarts on every stored character and on every pop. `raw_to` clears on a pop, and it is never 1 while `rx_empty` is 1.
- R8: `irq_lvl`, `irq_to` and `irq_ovr` equal their raw condition ANDed with `mask_lvl`, `mask_to` and `mask_ovr` respectively. `irq` is the OR of the three.
- R9: `rx_empty` is 1 exactly when nothing is stored. A pop while empty has no effect on the stored entries.
- R10: A change of `fifo_en` discards all stored entries and any character strobed in the same cycle. `rx_empty` is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 32-entry queue, 0: single holding slot |
| trig_sel | input | 3 | Fill-level trigger select |
| baud_tick | input | 1 | One pulse per bit period |
| char_valid | input | 1 | New character strobe |
| char_data | input | 8 | Received data byte |
| char_brk | input | 1 | Break error flag of the character |
| char_par | input | 1 | Parity error flag of the character |
| char_frm | input | 1 | Framing error flag of the character |
| pop | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| rd_par | output | 1 | Parity flag of the oldest entry |
| rd_frm | output | 1 | Framing flag of the oldest entry |
| rx_empty | output | 1 | Nothing stored |
| rx_full | output | 1 | Storage at capacity for the current mode |
| ovr_clr | input | 1 | Clear the overrun condition |
| mask_lvl | input | 1 | Enable for the level interrupt |
| mask_to | input | 1 | Enable for the timeout interrupt |
| mask_ovr | input | 1 | Enable for the overrun interrupt |
| raw_lvl | output | 1 | Raw fill-level condition |
| raw_to | output | 1 | Raw idle-timeout condition |
| raw_ovr | output | 1 | Raw sticky overrun condition |
| irq_lvl | output | 1 | Masked level interrupt |
| irq_to | output | 1 | Masked timeout interrupt |
| irq_ovr | output | 1 | Masked overrun interrupt |
| irq | output | 1 | OR of the masked interrupts |

## Verification
A push or pop shows up on the read outputs, `rx_empty`, `rx_full` and `raw_lvl` right after the rising edge that takes it. `raw_ovr` rises after the edge of the discarding strobe, and `raw_to` rises after the edge that takes the 32nd qualifying tick. The masked interrupts follow their raw conditions and masks with no register in between. The bench drives every input at the falling edge and advances its reference model right after the rising edge. It then compares all outputs at the following falling edge, so every result is checked in the first cycle it is due. Directed sequences place the 31st and 32nd tick and the trigger boundaries at known cycles, and seeded random traffic covers mode switches and coincident events.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    // Fill-level trigger in entries; single-slot mode always triggers at 1.
    function automatic logic [31:0] trig_entries(input logic [2:0] sel,
                                                 input logic fifo_mode,
                                                 input int unsigned depth);
        logic [31:0] t;
        if (!fifo_mode) begin
            t = 32'd1;
        end else begin
            case (sel)
                3'd0:    t = depth / 8;
                3'd1:    t = depth / 4;
                3'd3:    t = (depth * 6) / 8;
                3'd4:    t = (depth * 7) / 8;
                default: t = depth / 2;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fifo_en,
    input  logic                     push_req,
    input  logic                     pop_req,
    input  rx_entry_t                din,
    output rx_entry_t                dout,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty,
    output logic                     push_ok,
    output logic                     pop_ok,
    output logic                     flush
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP_DEEP   = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_SINGLE = CW'(1);
    localparam logic [AW-1:0] LAST_IDX   = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          mode;
    } store_st_t;

    store_st_t st_d, st_q;
    rx_entry_t mem [DEPTH];
    logic [CW-1:0] cap;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap     = fifo_en ? CAP_DEEP : CAP_SINGLE;
        flush   = (fifo_en != st_q.mode);
        full    = (st_q.cnt >= cap);
        empty   = (st_q.cnt == '0);
        push_ok = push_req && !full && !flush;
        pop_ok  = pop_req && !empty && !flush;

        st_d      = st_q;
        st_d.mode = fifo_en;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) st_d.wr = bump(st_q.wr);
            if (pop_ok)  st_d.rd = bump(st_q.rd);
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{wr: '0, rd: '0, cnt: '0, mode: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= din;
    end

    assign dout  = mem[st_q.rd];
    assign count = st_q.cnt;

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int TO_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic restart,
    input  logic clear,
    output logic to_flag
);
    localparam int CNTW = $clog2(TO_BITS + 1);
    localparam logic [CNTW-1:0] CNT_TOP  = CNTW'(TO_BITS);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(TO_BITS - 1);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            flag;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else begin
            if (tick && arm && !restart && (st_q.cnt == CNT_LAST))
                st_d.flag = 1'b1;
            if (restart || !arm)
                st_d.cnt = '0;
            else if (tick && (st_q.cnt < CNT_TOP))
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign to_flag = st_q.flag;

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fifo_en,
    input  logic [2:0]             trig_sel,
    input  logic [$clog2(DEPTH):0] count,
    input  logic                   ovr_set,
    input  logic                   ovr_clr,
    input  logic                   to_raw,
    input  logic                   mask_lvl,
    input  logic                   mask_to,
    input  logic                   mask_ovr,
    output logic                   lvl_raw,
    output logic                   ovr_raw,
    output logic                   irq_lvl,
    output logic                   irq_to,
    output logic                   irq_ovr,
    output logic                   irq_any
);
    typedef struct packed {
        logic ovr;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [31:0] trig;

    always_comb begin
        trig    = trig_entries(trig_sel, fifo_en, DEPTH);
        lvl_raw = (32'(count) >= trig);

        st_d = st_q;
        if (ovr_set)      st_d.ovr = 1'b1;
        else if (ovr_clr) st_d.ovr = 1'b0;

        irq_lvl = lvl_raw && mask_lvl;
        irq_to  = to_raw && mask_to;
        irq_ovr = st_q.ovr && mask_ovr;
        irq_any = irq_lvl || irq_to || irq_ovr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovr_raw = st_q.ovr;

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int TO_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic [2:0] trig_sel,
    input  logic       baud_tick,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    input  logic       char_brk,
    input  logic       char_par,
    input  logic       char_frm,
    input  logic       pop,
    output logic [7:0] rd_data,
    output logic       rd_brk,
    output logic       rd_par,
    output logic       rd_frm,
    output logic       rx_empty,
    output logic       rx_full,
    input  logic       ovr_clr,
    input  logic       mask_lvl,
    input  logic       mask_to,
    input  logic       mask_ovr,
    output logic       raw_lvl,
    output logic       raw_to,
    output logic       raw_ovr,
    output logic       irq_lvl,
    output logic       irq_to,
    output logic       irq_ovr,
    output logic       irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    rx_entry_t     in_ent, head_ent;
    logic [CW-1:0] occ_w;
    logic          full_w, empty_w, push_ok_w, pop_ok_w, flush_w;
    logic          lvl_w, to_w;
    logic          tmr_arm, tmr_restart, tmr_clear;

    assign in_ent = '{brk: char_brk, par: char_par, frm: char_frm, data: char_data};

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .push_req (char_valid),
        .pop_req  (pop),
        .din      (in_ent),
        .dout     (head_ent),
        .count    (occ_w),
        .full     (full_w),
        .empty    (empty_w),
        .push_ok  (push_ok_w),
        .pop_ok   (pop_ok_w),
        .flush    (flush_w)
    );

    assign tmr_arm     = !empty_w && !lvl_w;
    assign tmr_restart = push_ok_w || pop_ok_w;
    assign tmr_clear   = pop_ok_w || flush_w || empty_w;

    rxq_timer #(.TO_BITS(TO_BITS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .arm     (tmr_arm),
        .restart (tmr_restart),
        .clear   (tmr_clear),
        .to_flag (to_w)
    );

    rxq_status #(.DEPTH(DEPTH)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .count    (occ_w),
        .ovr_set  (char_valid && full_w),
        .ovr_clr  (ovr_clr),
        .to_raw   (to_w),
        .mask_lvl (mask_lvl),
        .mask_to  (mask_to),
        .mask_ovr (mask_ovr),
        .lvl_raw  (lvl_w),
        .ovr_raw  (raw_ovr),
        .irq_lvl  (irq_lvl),
        .irq_to   (irq_to),
        .irq_ovr  (irq_ovr),
        .irq_any  (irq)
    );

    assign rd_data  = head_ent.data;
    assign rd_brk   = head_ent.brk;
    assign rd_par   = head_ent.par;
    assign rd_frm   = head_ent.frm;
    assign rx_empty = empty_w;
    assign rx_full  = full_w;
    assign raw_lvl  = lvl_w;
    assign raw_to   = to_w;

endmodule

// File: rtl/uart_rxq_checker.sv
module uart_rxq_checker #(
    parameter int DEPTH = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fifo_en,
    input logic                   char_valid,
    input logic                   pop,
    input logic                   ovr_clr,
    input logic                   rx_empty,
    input logic                   rx_full,
    input logic                   raw_ovr,
    input logic                   raw_to,
    input logic                   irq_to,
    input logic                   mask_to,
    input logic [$clog2(DEPTH):0] occ
);
    AST_DEEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occ) <= DEPTH); // R1
    AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $stable(fifo_en)) |-> (occ <= 1)); // R2
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rx_full) |=> raw_ovr); // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_ovr && !ovr_clr) |=> raw_ovr); // R4
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(char_valid && rx_full)) |=> !raw_ovr); // R4
    AST_TO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rx_empty) |=> !raw_to); // R7
    AST_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !raw_to); // R7
    AST_TO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_to |-> !irq_to); // R8
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && rx_empty && !char_valid && $stable(fifo_en)) |=> rx_empty); // R9
endmodule

bind uart_rx_queue uart_rxq_checker #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .char_valid (char_valid),
    .pop        (pop),
    .ovr_clr    (ovr_clr),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .raw_ovr    (raw_ovr),
    .raw_to     (raw_to),
    .irq_to     (irq_to),
    .mask_to    (mask_to),
    .occ        (occ_w)
);

// File: tb/uart_rx_queue_tb_top.sv
module uart_rx_queue_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [2:0] trig_sel = 3'd2;
    logic       baud_tick = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_brk = 1'b0, char_par = 1'b0, char_frm = 1'b0;
    logic       pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_brk, rd_par, rd_frm, rx_empty, rx_full;
    logic       ovr_clr = 1'b0;
    logic       mask_lvl = 1'b0, mask_to = 1'b0, mask_ovr = 1'b0;
    logic       raw_lvl, raw_to, raw_ovr, irq_lvl, irq_to, irq_ovr, irq;

    int n_chk = 0;
    int n_err = 0;

    // reference model
    logic [10:0] mq[$];
    logic        m_mode = 1'b1;
    int          m_cnt = 0;
    logic        m_to = 1'b0;
    logic        m_ovr = 1'b0;

    always #4 clk = ~clk;

    uart_rx_queue dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .baud_tick(baud_tick), .char_valid(char_valid), .char_data(char_data),
        .char_brk(char_brk), .char_par(char_par), .char_frm(char_frm), .pop(pop),
        .rd_data(rd_data), .rd_brk(rd_brk), .rd_par(rd_par), .rd_frm(rd_frm),
        .rx_empty(rx_empty), .rx_full(rx_full), .ovr_clr(ovr_clr),
        .mask_lvl(mask_lvl), .mask_to(mask_to), .mask_ovr(mask_ovr),
        .raw_lvl(raw_lvl), .raw_to(raw_to), .raw_ovr(raw_ovr),
        .irq_lvl(irq_lvl), .irq_to(irq_to), .irq_ovr(irq_ovr), .irq(irq)
    );

    function automatic int exp_trig(input logic fe, input logic [2:0] s);
        if (!fe) return 1;
        case (s)
            3'd0: return 4;
            3'd1: return 8;
            3'd3: return 24;
            3'd4: return 28;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int   cap  = fifo_en ? 32 : 1;
        int   sz   = mq.size();
        logic fl   = (fifo_en != m_mode);
        logic full_m = (sz >= cap);
        logic push_ok = char_valid && !full_m && !fl;
        logic pop_ok  = pop && (sz > 0) && !fl;
        logic arm  = (sz > 0) && (sz < exp_trig(fifo_en, trig_sel));
        logic clr  = pop_ok || fl || (sz == 0);
        if (clr) begin
            m_cnt = 0;
            m_to  = 1'b0;
        end else begin
            if (baud_tick && arm && !push_ok && m_cnt == 31) m_to = 1'b1;
            if (push_ok || !arm) m_cnt = 0;
            else if (baud_tick && m_cnt < 32) m_cnt++;
        end
        if (char_valid && full_m) m_ovr = 1'b1;
        else if (ovr_clr)         m_ovr = 1'b0;
        if (fl) begin
            mq.delete();
        end else begin
            if (pop_ok)  void'(mq.pop_front());
            if (push_ok) mq.push_back({char_brk, char_par, char_frm, char_data});
        end
        m_mode = fifo_en;
    endtask

    task automatic compare();
        int   sz = mq.size();
        logic lv = (sz >= exp_trig(fifo_en, trig_sel));
        logic it = m_to && mask_to;
        logic il = lv && mask_lvl;
        logic io = m_ovr && mask_ovr;
        chk("R9 empty flag", 32'(rx_empty), 32'(sz == 0));
        chk("R2 full flag", 32'(rx_full), 32'(sz >= (fifo_en ? 32 : 1)));
        if (sz > 0) chk("R1 head entry", 32'({rd_brk, rd_par, rd_frm, rd_data}), 32'(mq[0]));
        chk("R5 level", 32'(raw_lvl), 32'(lv));
        chk("R6 timeout", 32'(raw_to), 32'(m_to));
        chk("R3 overrun", 32'(raw_ovr), 32'(m_ovr));
        chk("R8 interrupts", 32'({irq, irq_ovr, irq_to, irq_lvl}), 32'({il | it | io, io, it, il}));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) begin
            baud_tick = tk;
            cyc();
        end
        baud_tick = 1'b0;
    endtask

    task automatic push(input logic [10:0] e);
        char_valid = 1'b1;
        {char_brk, char_par, char_frm, char_data} = e;
        cyc();
        char_valid = 1'b0;
    endtask

    task automatic do_pop();
        pop = 1'b1;
        cyc();
        pop = 1'b0;
    endtask

    task automatic drain();
        while (!rx_empty) do_pop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset empty", 32'(rx_empty), 32'd1);
        chk("R4 reset overrun", 32'(raw_ovr), 32'd0);
        chk("R6 reset timeout", 32'(raw_to), 32'd0);

        // R1 / R3: fill, overflow, ordered drain
        for (int i = 0; i < 32; i++)
            push({(i % 5 == 0) ? 3'b101 : 3'b000, 8'(8'h40 + i)});
        chk("R3 full at 32", 32'(rx_full), 32'd1);
        push(11'h7ff);
        chk("R3 overrun raised", 32'(raw_ovr), 32'd1);
        chk("R3 lost entry not stored", 32'({rd_brk, rd_par, rd_frm, rd_data}), 32'h540);
        for (int i = 0; i < 32; i++) begin
            chk("R1 arrival order", 32'(rd_data), 32'(8'h40 + i));
            do_pop();
        end
        chk("R9 drained", 32'(rx_empty), 32'd1);
        do_pop();
        push(11'h123);
        chk("R9 pop on empty ignored", 32'({rd_brk, rd_par, rd_frm, rd_data}), 32'h123);
        idle(5, 1'b0);
        chk("R4 overrun held", 32'(raw_ovr), 32'd1);
        ovr_clr = 1'b1; cyc(); ovr_clr = 1'b0;
        chk("R4 overrun cleared", 32'(raw_ovr), 32'd0);
        drain();

        // R5: each trigger code
        for (int s = 0; s < 5; s++) begin
            trig_sel = 3'(s);
            for (int k = 0; k < exp_trig(1'b1, 3'(s)) - 1; k++) push(11'(k));
            chk("R5 below trigger", 32'(raw_lvl), 32'd0);
            push(11'h0aa);
            chk("R5 at trigger", 32'(raw_lvl), 32'd1);
            drain();
        end

        // R6 / R7 / R8: idle timeout
        trig_sel = 3'd2; mask_to = 1'b1;
        push(11'h011); push(11'h022); push(11'h033);
        idle(31, 1'b1);
        chk("R6 quiet after 31 ticks", 32'(raw_to), 32'd0);
        idle(1, 1'b1);
        chk("R6 timeout after 32 ticks", 32'(raw_to), 32'd1);
        chk("R8 timeout interrupt", 32'(irq_to), 32'd1);
        mask_to = 1'b0; cyc();
        chk("R8 masked timeout", 32'(irq_to), 32'd0);
        chk("R8 combined line", 32'(irq), 32'd0);
        do_pop();
        chk("R7 pop clears timeout", 32'(raw_to), 32'd0);
        idle(20, 1'b1);
        push(11'h044);
        idle(20, 1'b1);
        chk("R7 push restarts count", 32'(raw_to), 32'd0);
        idle(12, 1'b1);
        chk("R7 timeout after restart", 32'(raw_to), 32'd1);

        // R10 / R2: switch to single slot
        fifo_en = 1'b0; cyc();
        chk("R10 mode change flushes", 32'(rx_empty), 32'd1);
        push(11'h0c1);
        chk("R2 single slot full", 32'(rx_full), 32'd1);
        chk("R5 single slot level", 32'(raw_lvl), 32'd1);
        push(11'h0c2);
        chk("R2 first character kept", 32'(rd_data), 32'h0c1);
        idle(40, 1'b1);
        chk("R6 no timeout single slot", 32'(raw_to), 32'd0);
        do_pop();
        ovr_clr = 1'b1; cyc(); ovr_clr = 1'b0;
        fifo_en = 1'b1; cyc();

        // seeded random traffic
        for (int ph = 0; ph < 4; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                int pp = (ph == 0) ? 2 : (ph == 1) ? 6 : (ph == 2) ? 3 : 12;
                int pc = (ph == 3) ? 40 : 3;
                char_valid = ($urandom % pc) == 0;
                char_data  = 8'($urandom);
                {char_brk, char_par, char_frm} = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
                pop        = ($urandom % pp) == 0;
                baud_tick  = ($urandom % 2) == 0;
                ovr_clr    = ($urandom % 30) == 0;
                if (($urandom % 100) == 0) trig_sel = 3'($urandom);
                if (($urandom % 50) == 0) {mask_lvl, mask_to, mask_ovr} = 3'($urandom);
                if (($urandom % 400) == 0) fifo_en = ~fifo_en;
                cyc();
            end
        end
        char_valid = 1'b0; pop = 1'b0; baud_tick = 1'b0; ovr_clr = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule